// File: doc/BRIEF.md
# Load/Store Queue Allocation Tracker

This block keeps the bookkeeping for the two in-order rings that sit beside an out-of-order core's memory pipeline: one ring for loads, one for stores. Dispatch presents one memory operation per cycle, tagged as load or store and carrying its sequence number. The tracker assigns it the next tail slot of its own ring and reports, in the same cycle, the tail of the other ring so that later ordering checks can find which accesses are older or younger. Each ring has one slot more than its usable capacity, so equal head and tail always means empty. Dispatch reads a single free-entry figure: the tighter of the two rings.

A commit bound, given as the youngest committed sequence number, is held until replaced. Loads at the head at or below it leave one per cycle. Stores at or below it become eligible to write back, and the memory side then retires eligible stores from the store head. A squash bound removes younger entries from the tails, one per ring per cycle, with a busy output raised until the walk ends. The store walk never removes an entry that is already eligible. Sequence numbers are compared as plain unsigned values.

Top module: `lsq_alloc_tracker`

## Requirements
- R1: After reset both counts are 0, `squash_busy` and `sq_head_ready` are 0, and `free_count` equals the smaller of the two capacities.
- R2: An accepted load receives the current load tail as `alloc_lq_idx`, reports the current store tail on `alloc_sq_idx`, and sets `alloc_sq_none` to 1 exactly when the store ring is empty.
- R3: An accepted store receives the current store tail as `alloc_sq_idx` and reports the current load tail on `alloc_lq_idx`, with `alloc_sq_none` 0.
- R4: A ring of capacity C has C+1 slots numbered 0 to C; the slot after C is 0, and a tail moved back from 0 goes to C.
- R5: A request to a full ring gives `alloc_err`=1 and `alloc_ok`=0 in that cycle and changes no count; counts never exceed capacity.
- R6: `free_count` equals min(LQ_CAP - lq_count, SQ_CAP - sq_count).
- R7: While a commit bound is held and no squash is in progress, the load head leaves one per cycle while its sequence number is less than or equal to the bound; the first load above the bound stops the drain.
- R8: Stores whose sequence number is less than or equal to the held commit bound become writeback-eligible; `sq_head_ready` is 1 when the store head is eligible; `store_retire` removes the store head only then and is ignored otherwise.
- R9: After a squash, loads at the load tail with sequence number greater than the bound are removed one per cycle, and `squash_busy` stays 1 until no ring has anything more to remove.
- R10: The store squash walk removes tail stores above the bound and stops at the first store that is eligible or not above the bound.
- R11: An allocate request while `squash_busy` is 1, or in the cycle a squash is presented, is dropped: `alloc_ok` and `alloc_err` are both 0 and no count changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate request present |
| alloc_is_store | input | 1 | 1 = store, 0 = load |
| alloc_seq | input | 16 | Sequence number of the request |
| commit_valid | input | 1 | Load a new commit bound |
| commit_seq | input | 16 | Youngest committed sequence number |
| squash_valid | input | 1 | Start a squash walk |
| squash_seq | input | 16 | Entries above this sequence number are removed |
| store_retire | input | 1 | Memory side finished the head store |
| alloc_ok | output | 1 | Request accepted this cycle |
| alloc_err | output | 1 | Request rejected: target ring full |
| alloc_lq_idx | output | $clog2(LQ_CAP+1) | Load tail at the request |
| alloc_sq_idx | output | $clog2(SQ_CAP+1) | Store tail at the request |
| alloc_sq_none | output | 1 | Load request found the store ring empty |
| lq_count | output | $clog2(LQ_CAP+2) | Loads held |
| sq_count | output | $clog2(SQ_CAP+2) | Stores held |
| free_count | output | $clog2(LQ_CAP+2) | Entries dispatch may still use |
| squash_busy | output | 1 | Squash walk in progress |
| sq_head_ready | output | 1 | Store head is eligible to write back |

## Verification
The hardest situation to reach is a store squash that must halt on an eligible entry while younger, ineligible stores sit behind it across the wrap point of the store ring. The stimulus fills the store ring so its tail wraps to slot 0, sets a commit bound that covers only the oldest store, then squashes below every store; the walk must remove exactly the two younger ones. Allocation is attempted during that walk to show it is dropped, and the load ring is driven through a full, squashed, refilled and drained sequence so its tail rolls back across slot 0 as well.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    parameter int unsigned SEQ_W = 16;

    typedef logic [SEQ_W-1:0] seq_t;

    typedef enum logic {
        KIND_LOAD  = 1'b0,
        KIND_STORE = 1'b1
    } acc_kind_e;

    typedef struct packed {
        logic      valid;
        acc_kind_e kind;
        seq_t      seq;
    } alloc_req_t;

    // Next slot in a ring of n slots.
    function automatic int unsigned ring_inc(input int unsigned idx, input int unsigned n);
        return (idx + 1 == n) ? 0 : idx + 1;
    endfunction

    // Previous slot in a ring of n slots.
    function automatic int unsigned ring_dec(input int unsigned idx, input int unsigned n);
        return (idx == 0) ? n - 1 : idx - 1;
    endfunction

    function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/lsq_ring.sv
module lsq_ring
    import lsq_pkg::*;
#(
    parameter int unsigned N          = 5,
    parameter bit          TRACK_ELIG = 1'b0,
    localparam int unsigned IW        = $clog2(N),
    localparam int unsigned CW        = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  seq_t          push_seq,
    input  logic          pop_head,
    input  logic          pop_tail,
    input  logic          mark_en,
    input  seq_t          mark_bound,
    output logic [IW-1:0] tail_idx,
    output logic [CW-1:0] count,
    output seq_t          head_seq,
    output seq_t          last_seq,
    output logic          head_elig,
    output logic          last_elig
);

    seq_t          seq_q [N];
    logic [N-1:0]  elig_q;
    logic [IW-1:0] head_q;
    logic [IW-1:0] tail_q;
    logic [IW-1:0] last_idx;
    logic [CW-1:0] count_q;

    always_comb begin
        last_idx = IW'(ring_dec(int'(tail_q), N));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (push) begin
                tail_q <= IW'(ring_inc(int'(tail_q), N));
            end else if (pop_tail) begin
                tail_q <= last_idx;
            end
            if (pop_head) begin
                head_q <= IW'(ring_inc(int'(head_q), N));
            end
            count_q <= count_q + CW'(push) - CW'(pop_head) - CW'(pop_tail);
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            seq_q[tail_q] <= push_seq;
        end
    end

    generate
        if (TRACK_ELIG) begin : g_elig
            always_ff @(posedge clk) begin
                if (rst) begin
                    elig_q <= '0;
                end else begin
                    for (int i = 0; i < int'(N); i++) begin
                        if (push && (int'(tail_q) == i)) begin
                            elig_q[i] <= 1'b0;
                        end else if (mark_en && (seq_q[i] <= mark_bound)) begin
                            elig_q[i] <= 1'b1;
                        end
                    end
                end
            end
        end else begin : g_no_elig
            logic unused_mark;
            assign unused_mark = ^{mark_en, mark_bound};
            assign elig_q      = '0;
        end
    endgenerate

    assign tail_idx  = tail_q;
    assign count     = count_q;
    assign head_seq  = seq_q[head_q];
    assign last_seq  = seq_q[last_idx];
    assign head_elig = elig_q[head_q];
    assign last_elig = elig_q[last_idx];

endmodule

// File: rtl/lsq_commit_ctl.sv
module lsq_commit_ctl
    import lsq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic commit_valid,
    input  seq_t commit_seq,
    input  logic hold,
    input  logic lq_nonempty,
    input  seq_t lq_head_seq,
    output logic bound_valid,
    output seq_t bound,
    output logic ld_pop
);

    logic bound_valid_q;
    seq_t bound_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bound_valid_q <= 1'b0;
            bound_q       <= '0;
        end else if (commit_valid) begin
            bound_valid_q <= 1'b1;
            bound_q       <= commit_seq;
        end
    end

    assign bound_valid = bound_valid_q;
    assign bound       = bound_q;
    assign ld_pop      = bound_valid_q && !hold && lq_nonempty && (lq_head_seq <= bound_q);

endmodule

// File: rtl/lsq_squash_ctl.sv
module lsq_squash_ctl
    import lsq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic squash_valid,
    input  seq_t squash_seq,
    input  logic lq_nonempty,
    input  seq_t lq_last_seq,
    input  logic sq_nonempty,
    input  seq_t sq_last_seq,
    input  logic sq_last_elig,
    output logic busy,
    output logic ld_remove,
    output logic st_remove
);

    logic busy_q;
    seq_t bound_q;

    assign ld_remove = busy_q && lq_nonempty && (lq_last_seq > bound_q);
    assign st_remove = busy_q && sq_nonempty && !sq_last_elig && (sq_last_seq > bound_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            bound_q <= '0;
        end else if (squash_valid) begin
            busy_q  <= 1'b1;
            bound_q <= squash_seq;
        end else begin
            busy_q  <= ld_remove || st_remove;
        end
    end

    assign busy = busy_q;

endmodule

// File: rtl/lsq_alloc_tracker.sv
module lsq_alloc_tracker
    import lsq_pkg::*;
#(
    parameter int unsigned  LQ_CAP = 4,
    parameter int unsigned  SQ_CAP = 3,
    localparam int unsigned LQ_N   = LQ_CAP + 1,
    localparam int unsigned SQ_N   = SQ_CAP + 1,
    localparam int unsigned LQ_IW  = $clog2(LQ_N),
    localparam int unsigned SQ_IW  = $clog2(SQ_N),
    localparam int unsigned LQ_CW  = $clog2(LQ_N + 1),
    localparam int unsigned SQ_CW  = $clog2(SQ_N + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  alloc_valid,
    input  logic                  alloc_is_store,
    input  logic [SEQ_W-1:0]      alloc_seq,
    input  logic                  commit_valid,
    input  logic [SEQ_W-1:0]      commit_seq,
    input  logic                  squash_valid,
    input  logic [SEQ_W-1:0]      squash_seq,
    input  logic                  store_retire,
    output logic                  alloc_ok,
    output logic                  alloc_err,
    output logic [LQ_IW-1:0]      alloc_lq_idx,
    output logic [SQ_IW-1:0]      alloc_sq_idx,
    output logic                  alloc_sq_none,
    output logic [LQ_CW-1:0]      lq_count,
    output logic [SQ_CW-1:0]      sq_count,
    output logic [LQ_CW-1:0]      free_count,
    output logic                  squash_busy,
    output logic                  sq_head_ready
);

    alloc_req_t      req;
    logic            lq_full, sq_full, target_full, blocked;
    logic            lq_push, sq_push, sq_pop_head;
    logic            ld_pop, ld_remove, st_remove, busy;
    logic            bound_valid;
    seq_t            bound;
    logic [LQ_IW-1:0] lq_tail;
    logic [SQ_IW-1:0] sq_tail;
    logic [LQ_CW-1:0] lq_cnt;
    logic [SQ_CW-1:0] sq_cnt;
    seq_t            lq_head_seq, lq_last_seq, sq_head_seq, sq_last_seq;
    logic            lq_head_elig, lq_last_elig, sq_head_elig, sq_last_elig;
    logic            unused_ring;

    always_comb begin
        req.valid = alloc_valid;
        req.kind  = alloc_is_store ? KIND_STORE : KIND_LOAD;
        req.seq   = alloc_seq;
    end

    assign lq_full     = (int'(lq_cnt) == int'(LQ_CAP));
    assign sq_full     = (int'(sq_cnt) == int'(SQ_CAP));
    assign target_full = (req.kind == KIND_STORE) ? sq_full : lq_full;
    assign blocked     = busy || squash_valid;

    assign alloc_ok  = req.valid && !blocked && !target_full;
    assign alloc_err = req.valid && !blocked && target_full;
    assign lq_push   = alloc_ok && (req.kind == KIND_LOAD);
    assign sq_push   = alloc_ok && (req.kind == KIND_STORE);

    assign sq_pop_head = store_retire && (sq_cnt != '0) && sq_head_elig;

    lsq_ring #(.N(LQ_N), .TRACK_ELIG(1'b0)) u_lq (
        .clk        (clk),
        .rst        (rst),
        .push       (lq_push),
        .push_seq   (req.seq),
        .pop_head   (ld_pop),
        .pop_tail   (ld_remove),
        .mark_en    (1'b0),
        .mark_bound (bound),
        .tail_idx   (lq_tail),
        .count      (lq_cnt),
        .head_seq   (lq_head_seq),
        .last_seq   (lq_last_seq),
        .head_elig  (lq_head_elig),
        .last_elig  (lq_last_elig)
    );

    lsq_ring #(.N(SQ_N), .TRACK_ELIG(1'b1)) u_sq (
        .clk        (clk),
        .rst        (rst),
        .push       (sq_push),
        .push_seq   (req.seq),
        .pop_head   (sq_pop_head),
        .pop_tail   (st_remove),
        .mark_en    (bound_valid),
        .mark_bound (bound),
        .tail_idx   (sq_tail),
        .count      (sq_cnt),
        .head_seq   (sq_head_seq),
        .last_seq   (sq_last_seq),
        .head_elig  (sq_head_elig),
        .last_elig  (sq_last_elig)
    );

    assign unused_ring = ^{lq_head_elig, lq_last_elig, sq_head_seq};

    lsq_commit_ctl u_commit (
        .clk          (clk),
        .rst          (rst),
        .commit_valid (commit_valid),
        .commit_seq   (commit_seq),
        .hold         (busy),
        .lq_nonempty  (lq_cnt != '0),
        .lq_head_seq  (lq_head_seq),
        .bound_valid  (bound_valid),
        .bound        (bound),
        .ld_pop       (ld_pop)
    );

    lsq_squash_ctl u_squash (
        .clk          (clk),
        .rst          (rst),
        .squash_valid (squash_valid),
        .squash_seq   (squash_seq),
        .lq_nonempty  (lq_cnt != '0),
        .lq_last_seq  (lq_last_seq),
        .sq_nonempty  (sq_cnt != '0),
        .sq_last_seq  (sq_last_seq),
        .sq_last_elig (sq_last_elig),
        .busy         (busy),
        .ld_remove    (ld_remove),
        .st_remove    (st_remove)
    );

    assign alloc_lq_idx  = lq_tail;
    assign alloc_sq_idx  = sq_tail;
    assign alloc_sq_none = (req.kind == KIND_LOAD) && (sq_cnt == '0);
    assign lq_count      = lq_cnt;
    assign sq_count      = sq_cnt;
    assign free_count    = LQ_CW'(min_u(LQ_CAP - int'(lq_cnt), SQ_CAP - int'(sq_cnt)));
    assign squash_busy   = busy;
    assign sq_head_ready = (sq_cnt != '0) && sq_head_elig;

endmodule

// File: rtl/lsq_alloc_tracker_chk.sv
module lsq_alloc_tracker_chk #(
    parameter int unsigned  LQ_CAP = 4,
    parameter int unsigned  SQ_CAP = 3,
    localparam int unsigned LQ_CW  = $clog2(LQ_CAP + 2),
    localparam int unsigned SQ_CW  = $clog2(SQ_CAP + 2)
) (
    input logic             clk,
    input logic             rst,
    input logic             alloc_valid,
    input logic             alloc_is_store,
    input logic             squash_valid,
    input logic             alloc_ok,
    input logic             alloc_err,
    input logic [LQ_CW-1:0] lq_count,
    input logic [SQ_CW-1:0] sq_count,
    input logic [LQ_CW-1:0] free_count,
    input logic             squash_busy
);

    AST_LQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        int'(lq_count) <= int'(LQ_CAP)); // R5

    AST_SQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        int'(sq_count) <= int'(SQ_CAP)); // R5

    AST_OK_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(alloc_ok && alloc_err)); // R5

    AST_ERR_NO_LOAD_GROWTH: assert property (@(posedge clk) disable iff (rst)
        (alloc_err && !alloc_is_store) |=> (lq_count <= $past(lq_count))); // R5

    AST_FREE_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        (int'(free_count) + int'(lq_count) <= int'(LQ_CAP)) &&
        (int'(free_count) + int'(sq_count) <= int'(SQ_CAP))); // R6

    AST_LQ_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        ##1 (int'($past(lq_count)) <= int'(lq_count) + 1)); // R7

    AST_SQ_SQUASH_STEP: assert property (@(posedge clk) disable iff (rst)
        squash_busy |=> (int'($past(sq_count)) <= int'(sq_count) + 2)); // R10

    AST_BUSY_NO_ALLOC: assert property (@(posedge clk) disable iff (rst)
        (squash_busy || squash_valid) |-> !(alloc_ok || alloc_err)); // R11

    AST_BUSY_LOAD_SHRINK: assert property (@(posedge clk) disable iff (rst)
        (squash_busy && !alloc_valid) |=> (lq_count <= $past(lq_count))); // R9

endmodule

bind lsq_alloc_tracker lsq_alloc_tracker_chk #(.LQ_CAP(LQ_CAP), .SQ_CAP(SQ_CAP)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .alloc_valid    (alloc_valid),
    .alloc_is_store (alloc_is_store),
    .squash_valid   (squash_valid),
    .alloc_ok       (alloc_ok),
    .alloc_err      (alloc_err),
    .lq_count       (lq_count),
    .sq_count       (sq_count),
    .free_count     (free_count),
    .squash_busy    (squash_busy)
);

// File: tb/lsq_alloc_tracker_tb.sv
module lsq_alloc_tracker_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        alloc_valid = 1'b0;
    logic        alloc_is_store = 1'b0;
    logic [15:0] alloc_seq = '0;
    logic        commit_valid = 1'b0;
    logic [15:0] commit_seq = '0;
    logic        squash_valid = 1'b0;
    logic [15:0] squash_seq = '0;
    logic        store_retire = 1'b0;
    logic        alloc_ok, alloc_err, alloc_sq_none, squash_busy, sq_head_ready;
    logic [2:0]  alloc_lq_idx;
    logic [1:0]  alloc_sq_idx;
    logic [2:0]  lq_count, free_count, sq_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lsq_alloc_tracker u_dut (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_is_store(alloc_is_store), .alloc_seq(alloc_seq),
        .commit_valid(commit_valid), .commit_seq(commit_seq),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .store_retire(store_retire),
        .alloc_ok(alloc_ok), .alloc_err(alloc_err),
        .alloc_lq_idx(alloc_lq_idx), .alloc_sq_idx(alloc_sq_idx), .alloc_sq_none(alloc_sq_none),
        .lq_count(lq_count), .sq_count(sq_count), .free_count(free_count),
        .squash_busy(squash_busy), .sq_head_ready(sq_head_ready)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Drive one request at a falling edge, sample the same-cycle outputs.
    task automatic alloc(input bit st, input int seq, input int exp_ok, input int exp_lq,
                         input int exp_sq, input int exp_none, input string tag);
        @(negedge clk);
        alloc_valid = 1'b1; alloc_is_store = st; alloc_seq = 16'(seq);
        #2;
        check({tag, " ok"}, int'(alloc_ok), exp_ok);
        check({tag, " err"}, int'(alloc_err), 1 - exp_ok);
        if (exp_ok == 1) begin
            check({tag, " lq_idx"}, int'(alloc_lq_idx), exp_lq);
            check({tag, " sq_idx"}, int'(alloc_sq_idx), exp_sq);
            check({tag, " none"}, int'(alloc_sq_none), exp_none);
        end
        @(posedge clk); #1;
        alloc_valid = 1'b0;
    endtask

    task automatic commit(input int seq);
        @(negedge clk);
        commit_valid = 1'b1; commit_seq = 16'(seq);
        @(posedge clk); #1;
        commit_valid = 1'b0;
    endtask

    task automatic retire();
        @(negedge clk);
        store_retire = 1'b1;
        @(posedge clk); #1;
        store_retire = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20 && squash_busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 lq_count", int'(lq_count), 0);
        check("R1 sq_count", int'(sq_count), 0);
        check("R1 busy", int'(squash_busy), 0);
        check("R1 head_ready", int'(sq_head_ready), 0);
        check("R1 free", int'(free_count), 3);
    endtask

    task automatic t_basic_alloc();
        alloc(1'b0, 10, 1, 0, 0, 1, "R2 load into empty rings");
        alloc(1'b1, 11, 1, 1, 0, 0, "R3 store records load tail");
        alloc(1'b0, 12, 1, 1, 1, 0, "R2 load records store tail");
        @(negedge clk);
        check("R6 free after 2L1S", int'(free_count), 2);
    endtask

    task automatic t_commit_and_retire();
        commit(11);
        idle(5);
        check("R7 drain stops above bound", int'(lq_count), 1);
        check("R8 head store eligible", int'(sq_head_ready), 1);
        retire();
        @(negedge clk);
        check("R8 retire eligible head", int'(sq_count), 0);
        retire();
        @(negedge clk);
        check("R8 retire on empty ignored", int'(sq_count), 0);
        alloc(1'b1, 20, 1, 2, 1, 0, "R3 second store");
        idle(2);
        check("R8 fresh store not eligible", int'(sq_head_ready), 0);
        retire();
        @(negedge clk);
        check("R8 retire of ineligible head ignored", int'(sq_count), 1);
    endtask

    task automatic t_full_and_squash_loads();
        alloc(1'b0, 21, 1, 2, 2, 0, "R2 load 21");
        alloc(1'b0, 22, 1, 3, 2, 0, "R2 load 22");
        alloc(1'b0, 23, 1, 4, 2, 0, "R4 load into top slot");
        alloc(1'b0, 24, 0, 0, 0, 0, "R5 load to full ring");
        @(negedge clk);
        check("R5 count unchanged after reject", int'(lq_count), 4);
        check("R6 free with full load ring", int'(free_count), 0);
        @(negedge clk);
        squash_valid = 1'b1; squash_seq = 16'd21;
        @(posedge clk); #1;
        squash_valid = 1'b0;
        @(negedge clk);
        check("R9 busy during walk", int'(squash_busy), 1);
        wait_idle();
        check("R9 busy cleared", int'(squash_busy), 0);
        check("R9 loads left", int'(lq_count), 2);
        check("R10 older store kept", int'(sq_count), 1);
        alloc(1'b0, 30, 1, 3, 2, 0, "R4 tail moved back across 0");
        alloc(1'b0, 31, 1, 4, 2, 0, "R2 load 31");
    endtask

    task automatic t_wrap_and_store_squash();
        commit(100);
        idle(8);
        check("R7 full drain", int'(lq_count), 0);
        retire();
        @(negedge clk);
        check("R8 store 20 retired", int'(sq_count), 0);
        alloc(1'b0, 140, 1, 0, 2, 1, "R4 load tail wraps to 0");
        alloc(1'b1, 141, 1, 1, 2, 0, "R3 store 141");
        alloc(1'b1, 142, 1, 1, 3, 0, "R3 store 142");
        alloc(1'b1, 143, 1, 1, 0, 0, "R4 store tail wraps to 0");
        alloc(1'b1, 144, 0, 0, 0, 0, "R5 store to full ring");
        @(negedge clk);
        check("R5 store count unchanged", int'(sq_count), 3);
        check("R6 free limited by store ring", int'(free_count), 0);
        commit(141);
        idle(4);
        check("R7 load 140 drained", int'(lq_count), 0);
        check("R8 store 141 eligible", int'(sq_head_ready), 1);
        @(negedge clk);
        squash_valid = 1'b1; squash_seq = 16'd100;
        alloc_valid = 1'b1; alloc_is_store = 1'b0; alloc_seq = 16'd150;
        #2;
        check("R11 alloc with squash same cycle ok", int'(alloc_ok), 0);
        check("R11 alloc with squash same cycle err", int'(alloc_err), 0);
        @(posedge clk); #1;
        squash_valid = 1'b0;
        @(negedge clk);
        #2;
        check("R11 alloc during busy ok", int'(alloc_ok), 0);
        check("R11 alloc during busy err", int'(alloc_err), 0);
        @(posedge clk); #1;
        alloc_valid = 1'b0;
        wait_idle();
        check("R10 walk stops at eligible store", int'(sq_count), 1);
        check("R11 dropped load not added", int'(lq_count), 0);
        check("R6 free after squash", int'(free_count), 2);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_basic_alloc();
        t_commit_and_retire();
        t_full_and_squash_loads();
        t_wrap_and_store_squash();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule